// File: doc/BRIEF.md
# MMC Host Register and Interrupt Front-End

This block is the software-visible face of a simple MMC/SD host controller. A 32-bit register bus reads and writes a small file of control registers: the command argument, the command word, the block geometry, the address of the transfer buffer, and four response words. Writing the command word starts the command. The block splits that word into the fields a card-side engine needs and sends a one-cycle launch strobe with them.

In the other direction, the block gathers the engine's events into a four-bit interrupt status register. The events are command finished, data finished, command timed out, and a change in card presence or write protection. Software clears status bits by writing ones. The enable register masks each bit before it reaches a single interrupt line. The engine also returns the card's response, and the block keeps it as either one short word or four long words, depending on the response type of the command that was launched.

Top module: `mmc_host_regs`

## Requirements
- R1: After reset, interrupt status, interrupt enable, the command word, the argument, the buffer address, the block geometry and all response words read 0. The interrupt line and the launch strobe are low, and the command is not busy.
- R2: The stored command word is decoded as follows: opcode in bits 5:0, open-drain flag in bit 6, response type in bits 9:8 (0 none, 1 short, 2 long 136-bit, 3 short operating-condition), busy-wait flag in bit 11, command class in bits 13:12 (0 broadcast, 1 broadcast with response, 2 addressed, 3 addressed with data), and card-to-host direction in bit 15. Bits 7, 10 and 14 read back as 0.
- R3: Register byte offsets are: 0x00 interrupt status, 0x04 interrupt enable, 0x08 buffer address, 0x0C command, 0x10 argument, 0x14/0x18/0x1C/0x20 response words 0 to 3, 0x24 block length, 0x28 block count, 0x2C card state. Writes show on read-back and on the engine outputs in the cycle after the write edge. An accepted command write raises the launch strobe for exactly that one cycle.
- R4: A command write while a command is busy is ignored: no strobe is sent and the stored word is unchanged. Busy is set when a command is accepted, cleared by end of command or by timeout, and readable as card-state bit 2.
- R5: Interrupt status bit 0 is end of command, bit 1 end of data, bit 2 card state change, and bit 3 command timeout. Each is set in the cycle after its event.
- R6: A timeout that arrives in the same cycle as end of command sets only bit 3, not bit 0.
- R7: Writing to the status register clears each bit that is written as 1 and leaves the other bits unchanged. An event arriving in the same cycle as a clear of its bit wins, so the bit stays set.
- R8: The interrupt line is high exactly when some status bit and its enable bit (enable register bits 3:0) are both 1. Writing 0 to the enable register drops the line and leaves the status unchanged.
- R9: Card-state bit 0 shows card present and bit 1 shows read-only. A change in either input sets status bit 2 one cycle later.
- R10: A response capture for a long-type command fills word 0 with bits 31:0, word 1 with bits 63:32, and so on up to word 3 with bits 127:96. A capture for any other type fills word 0 with bits 31:0 and sets words 1 to 3 to 0.
- R11: Block length and block count each hold 11 bits (the value minus one). Bits above bit 10 are dropped on write and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Masked interrupt request |
| cmd_go | output | 1 | One-cycle command launch strobe |
| cmd_opcode | output | 6 | Command opcode |
| cmd_open_drain | output | 1 | Open-drain signalling requested |
| cmd_rsp_type | output | 2 | Response type |
| cmd_busy_wait | output | 1 | Command waits on card busy |
| cmd_class | output | 2 | Command class |
| cmd_read | output | 1 | Data moves card to host |
| cmd_arg | output | 32 | Command argument |
| buf_addr | output | 32 | Transfer buffer address |
| blk_len | output | 11 | Block length minus one |
| blk_cnt | output | 11 | Block count minus one |
| eng_cmd_done | input | 1 | Engine: command finished |
| eng_data_done | input | 1 | Engine: data phase finished |
| eng_timeout | input | 1 | Engine: command timed out |
| eng_rsp_valid | input | 1 | Engine: response present on eng_rsp |
| eng_rsp | input | 128 | Engine: response bits |
| card_present | input | 1 | Card inserted (synchronous) |
| card_ro | input | 1 | Card write-protected (synchronous) |

## Verification
All writes and engine events take effect at one clock edge. Their results (read-back, decoded fields, launch strobe, status bits, stored responses and busy) are due in the cycle that follows that edge. The interrupt line follows the status and enable registers without any further register. The bench drives every stimulus on a falling edge, holds it across one rising edge, and reads results at the next falling edge, exactly one cycle later. The launch strobe is also checked one cycle after that, when it must have dropped. Read data is combinational, so the bench sets the address and samples it a short delay later, away from any rising edge.

// File: rtl/mmc_host_pkg.sv
// Shared constants and types for the MMC host register front-end.
// Assumes a byte-addressed register bus with 32-bit aligned registers.
package mmc_host_pkg;

    localparam int ADDR_W   = 6;
    localparam int CMD_W    = 16;
    localparam int NUM_EVT  = 4;

    localparam logic [ADDR_W-1:0] OFS_ISTAT  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_BUF    = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_CMD    = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_ARG    = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_RSP0   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_BLKLEN = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_BLKCNT = 6'h28;
    localparam logic [ADDR_W-1:0] OFS_CSTATE = 6'h2C;

    // Event bit positions in the interrupt status register
    localparam int EVT_CMD   = 0;
    localparam int EVT_DATA  = 1;
    localparam int EVT_CARD  = 2;
    localparam int EVT_TMO   = 3;

    // Defined bits of the command word; the rest are kept at zero
    localparam logic [CMD_W-1:0] CMD_KEEP_MASK = 16'hBB7F;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_SHORT = 2'd1,
        RSP_LONG  = 2'd2,
        RSP_OCR   = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        CLS_BCAST      = 2'd0,
        CLS_BCAST_RSP  = 2'd1,
        CLS_ADDR       = 2'd2,
        CLS_ADDR_DATA  = 2'd3
    } cmd_class_e;

    typedef struct packed {
        logic       rd_dir;
        cmd_class_e cls;
        logic       busy_wait;
        rsp_kind_e  rsp;
        logic       open_drain;
        logic [5:0] opcode;
    } cmd_fields_t;

endpackage

// File: rtl/mmc_cmd_decode.sv
// Splits a stored command word into its fields.
// Assumes the word has already been masked to its defined bits.
module mmc_cmd_decode
    import mmc_host_pkg::*;
(
    input  logic [CMD_W-1:0] word,
    output cmd_fields_t      fields
);

    // Field extraction by fixed bit position
    always_comb begin
        fields.opcode     = word[5:0];
        fields.open_drain = word[6];
        fields.rsp        = rsp_kind_e'(word[9:8]);
        fields.busy_wait  = word[11];
        fields.cls        = cmd_class_e'(word[13:12]);
        fields.rd_dir     = word[15];
    end

endmodule

// File: rtl/mmc_cmd_launch.sv
// Holds the command word, the busy flag and the launch strobe.
// Assumes the engine reports completion with eng_done or eng_timeout.
module mmc_cmd_launch
    import mmc_host_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmd,
    input  logic [CMD_W-1:0] wr_word,
    input  logic             eng_done,
    input  logic             eng_timeout,
    output logic [CMD_W-1:0] cmd_word,
    output logic             busy,
    output logic             go
);

    logic accept;

    // A command write is taken only when no command is in flight
    assign accept = wr_cmd && !busy;

    // Command word storage, busy tracking and strobe generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_word <= '0;
            busy     <= 1'b0;
            go       <= 1'b0;
        end else begin
            go <= accept;
            if (accept) begin
                cmd_word <= wr_word & CMD_KEEP_MASK;
                busy     <= 1'b1;
            end else if (eng_done || eng_timeout) begin
                busy     <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mmc_irq_ctrl.sv
// Write-one-to-clear interrupt status with per-bit enable.
// Assumes set and clear may coincide; a set always wins.
module mmc_irq_ctrl #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_set,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_bits,
    input  logic         en_wr,
    input  logic [N-1:0] en_bits,
    output logic [N-1:0] status,
    output logic [N-1:0] enable,
    output logic         irq
);

    logic [N-1:0] clr_eff;

    // Clear vector is active only during a status write
    assign clr_eff = clr_wr ? clr_bits : '0;

    // Per-bit status update, set taking priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (evt_set[i])
                    status[i] <= 1'b1;
                else if (clr_eff[i])
                    status[i] <= 1'b0;
            end
        end
    end

    // Enable register
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable <= '0;
        else if (en_wr)
            enable <= en_bits;
    end

    // Masked request line
    assign irq = |(status & enable);

endmodule

// File: rtl/mmc_resp_store.sv
// Response word bank; word 0 is always loaded, higher words only for long
// responses and zeroed otherwise.
// Assumes the response bus holds bits 31:0 in its lowest word.
module mmc_resp_store #(
    parameter int WORDS  = 4,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    capture,
    input  logic                    is_long,
    input  logic [WORDS*DATA_W-1:0] rsp_in,
    output logic [WORDS*DATA_W-1:0] rsp_words
);

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        if (g == 0) begin : g_low
            // Lowest word captured for every response kind
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rsp_words[DATA_W-1:0] <= '0;
                else if (capture)
                    rsp_words[DATA_W-1:0] <= rsp_in[DATA_W-1:0];
            end
        end else begin : g_high
            // Upper words loaded for long responses, zeroed for short
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rsp_words[g*DATA_W +: DATA_W] <= '0;
                else if (capture)
                    rsp_words[g*DATA_W +: DATA_W] <=
                        is_long ? rsp_in[g*DATA_W +: DATA_W] : '0;
            end
        end
    end

endmodule

// File: rtl/mmc_host_regs.sv
// MMC host register file and interrupt front-end.
// Assumes card_present/card_ro are already synchronous to clk and that
// engine event inputs are single-cycle pulses.
module mmc_host_regs
    import mmc_host_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int GEOM_W    = 11,
    parameter int RSP_WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        irq,
    output logic                        cmd_go,
    output logic [5:0]                  cmd_opcode,
    output logic                        cmd_open_drain,
    output logic [1:0]                  cmd_rsp_type,
    output logic                        cmd_busy_wait,
    output logic [1:0]                  cmd_class,
    output logic                        cmd_read,
    output logic [DATA_W-1:0]           cmd_arg,
    output logic [DATA_W-1:0]           buf_addr,
    output logic [GEOM_W-1:0]           blk_len,
    output logic [GEOM_W-1:0]           blk_cnt,
    input  logic                        eng_cmd_done,
    input  logic                        eng_data_done,
    input  logic                        eng_timeout,
    input  logic                        eng_rsp_valid,
    input  logic [RSP_WORDS*DATA_W-1:0] eng_rsp,
    input  logic                        card_present,
    input  logic                        card_ro
);

    localparam int STEP = DATA_W / 8;

    logic                        cmd_wr_hit;
    logic [CMD_W-1:0]            cmd_word;
    logic                        cmd_busy;
    cmd_fields_t                 cmd_f;
    logic [NUM_EVT-1:0]          evt_set;
    logic [NUM_EVT-1:0]          irq_status;
    logic [NUM_EVT-1:0]          irq_enable;
    logic [1:0]                  card_prev;
    logic                        card_changed;
    logic [RSP_WORDS*DATA_W-1:0] rsp_words;
    logic [DATA_W-1:0]           rd_mux;

    // Command write decode
    assign cmd_wr_hit = bus_wr && (bus_addr == OFS_CMD);

    mmc_cmd_launch u_launch (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_cmd      (cmd_wr_hit),
        .wr_word     (bus_wdata[CMD_W-1:0]),
        .eng_done    (eng_cmd_done),
        .eng_timeout (eng_timeout),
        .cmd_word    (cmd_word),
        .busy        (cmd_busy),
        .go          (cmd_go)
    );

    mmc_cmd_decode u_decode (
        .word   (cmd_word),
        .fields (cmd_f)
    );

    // Decoded fields toward the engine
    assign cmd_opcode     = cmd_f.opcode;
    assign cmd_open_drain = cmd_f.open_drain;
    assign cmd_rsp_type   = cmd_f.rsp;
    assign cmd_busy_wait  = cmd_f.busy_wait;
    assign cmd_class      = cmd_f.cls;
    assign cmd_read       = cmd_f.rd_dir;

    // Plain data registers: argument, buffer address, block geometry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_arg  <= '0;
            buf_addr <= '0;
            blk_len  <= '0;
            blk_cnt  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_ARG:    cmd_arg  <= bus_wdata;
                OFS_BUF:    buf_addr <= bus_wdata;
                OFS_BLKLEN: blk_len  <= bus_wdata[GEOM_W-1:0];
                OFS_BLKCNT: blk_cnt  <= bus_wdata[GEOM_W-1:0];
                default:    ;
            endcase
        end
    end

    // Card state history; tracks inputs during reset so no event follows it
    always_ff @(posedge clk) begin
        card_prev <= {card_ro, card_present};
    end

    assign card_changed = (card_prev != {card_ro, card_present});

    // Event vector; timeout displaces end of command in the same cycle
    always_comb begin
        evt_set           = '0;
        evt_set[EVT_CMD]  = eng_cmd_done && !eng_timeout;
        evt_set[EVT_DATA] = eng_data_done;
        evt_set[EVT_CARD] = card_changed;
        evt_set[EVT_TMO]  = eng_timeout;
    end

    mmc_irq_ctrl #(.N(NUM_EVT)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_set  (evt_set),
        .clr_wr   (bus_wr && (bus_addr == OFS_ISTAT)),
        .clr_bits (bus_wdata[NUM_EVT-1:0]),
        .en_wr    (bus_wr && (bus_addr == OFS_IEN)),
        .en_bits  (bus_wdata[NUM_EVT-1:0]),
        .status   (irq_status),
        .enable   (irq_enable),
        .irq      (irq)
    );

    mmc_resp_store #(.WORDS(RSP_WORDS), .DATA_W(DATA_W)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (eng_rsp_valid),
        .is_long   (cmd_f.rsp == RSP_LONG),
        .rsp_in    (eng_rsp),
        .rsp_words (rsp_words)
    );

    // Read multiplexer over all registers
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            OFS_ISTAT:  rd_mux = DATA_W'(irq_status);
            OFS_IEN:    rd_mux = DATA_W'(irq_enable);
            OFS_BUF:    rd_mux = buf_addr;
            OFS_CMD:    rd_mux = DATA_W'(cmd_word);
            OFS_ARG:    rd_mux = cmd_arg;
            OFS_BLKLEN: rd_mux = DATA_W'(blk_len);
            OFS_BLKCNT: rd_mux = DATA_W'(blk_cnt);
            OFS_CSTATE: rd_mux = DATA_W'({cmd_busy, card_ro, card_present});
            default:    ;
        endcase
        for (int i = 0; i < RSP_WORDS; i++) begin
            if (bus_addr == OFS_RSP0 + ADDR_W'(STEP * i))
                rd_mux = rsp_words[i*DATA_W +: DATA_W];
        end
    end

    assign bus_rdata = rd_mux;

endmodule

// File: rtl/mmc_host_regs_chk.sv
// Property checker for mmc_host_regs, attached with bind below.
// Assumes the event bit order of mmc_host_pkg.
module mmc_host_regs_chk
    import mmc_host_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_go,
    input logic               busy,
    input logic               cmd_wr,
    input logic [NUM_EVT-1:0] status,
    input logic [NUM_EVT-1:0] enable,
    input logic               irq,
    input logic               eng_timeout,
    input logic               eng_data_done,
    input logic               card_present,
    input logic               card_ro
);

    p_go_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> !cmd_go);

    p_go_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> busy);

    p_ignore_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> !cmd_go);

    p_tmo_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_timeout |=> status[EVT_TMO]);

    p_tmo_no_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_timeout && !status[EVT_CMD]) |=> !status[EVT_CMD]);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_data_done |=> status[EVT_DATA]);

    p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq);

    p_card_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({card_present, card_ro}) |=> status[EVT_CARD]);

endmodule

bind mmc_host_regs mmc_host_regs_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_go        (cmd_go),
    .busy          (cmd_busy),
    .cmd_wr        (cmd_wr_hit),
    .status        (irq_status),
    .enable        (irq_enable),
    .irq           (irq),
    .eng_timeout   (eng_timeout),
    .eng_data_done (eng_data_done),
    .card_present  (card_present),
    .card_ro       (card_ro)
);

// File: tb/tb_mmc_host_regs.sv
`timescale 1ns/1ps
module tb_mmc_host_regs;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq, cmd_go, cmd_open_drain, cmd_busy_wait, cmd_read;
    logic [5:0]   cmd_opcode;
    logic [1:0]   cmd_rsp_type, cmd_class;
    logic [31:0]  cmd_arg, buf_addr;
    logic [10:0]  blk_len, blk_cnt;
    logic         eng_cmd_done = 1'b0, eng_data_done = 1'b0;
    logic         eng_timeout = 1'b0, eng_rsp_valid = 1'b0;
    logic [127:0] eng_rsp = '0;
    logic         card_present = 1'b0, card_ro = 1'b0;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    mmc_host_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .cmd_go(cmd_go), .cmd_opcode(cmd_opcode),
        .cmd_open_drain(cmd_open_drain), .cmd_rsp_type(cmd_rsp_type),
        .cmd_busy_wait(cmd_busy_wait), .cmd_class(cmd_class),
        .cmd_read(cmd_read), .cmd_arg(cmd_arg), .buf_addr(buf_addr),
        .blk_len(blk_len), .blk_cnt(blk_cnt),
        .eng_cmd_done(eng_cmd_done), .eng_data_done(eng_data_done),
        .eng_timeout(eng_timeout), .eng_rsp_valid(eng_rsp_valid),
        .eng_rsp(eng_rsp), .card_present(card_present), .card_ro(card_ro)
    );

    // Register read-back vectors: offset, written value, expected read
    localparam int NV = 7;
    localparam logic [69:0] VEC [NV] = '{
        {6'h08, 32'h8000_1000, 32'h8000_1000},  // R3 buffer address
        {6'h10, 32'hA5A5_0F0F, 32'hA5A5_0F0F},  // R3 argument
        {6'h24, 32'h0000_01FF, 32'h0000_01FF},  // R11 block length
        {6'h24, 32'hFFFF_FFFF, 32'h0000_07FF},  // R11 upper bits dropped
        {6'h28, 32'h0000_F800, 32'h0000_0000},  // R11 only bits above 10
        {6'h28, 32'h0000_0007, 32'h0000_0007},  // R11 block count
        {6'h04, 32'hFFFF_FFFF, 32'h0000_000F}   // R8 enable width
    };

    task automatic check(input string tag, input logic [127:0] got,
                         input logic [127:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Watchdog: counts as a failed check and still reports
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(6'h00, v); check("R1 status", v, 0);
        rd(6'h04, v); check("R1 enable", v, 0);
        rd(6'h0C, v); check("R1 command", v, 0);
        rd(6'h14, v); check("R1 rsp0", v, 0);
        rd(6'h2C, v); check("R1 state", v, 0);
        check("R1 irq", irq, 0);
        check("R1 go", cmd_go, 0);

        // Table walk: write then read back (R3, R11, R8)
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][69:64], VEC[i][63:32]);
            rd(VEC[i][69:64], v);
            check($sformatf("R3/R11 vector %0d", i), v, VEC[i][31:0]);
        end
        check("R3 arg port", cmd_arg, 32'hA5A5_0F0F);
        check("R3 buffer port", buf_addr, 32'h8000_1000);
        check("R11 length port", blk_len, 11'h7FF);
        check("R11 count port", blk_cnt, 11'h007);

        // R2 decode with junk in bits 7, 10, 14
        wr(6'h10, 32'h1234_5678);
        wr(6'h0C, 32'hFFFF_FDD1);
        check("R3 go high", cmd_go, 1);
        check("R2 opcode", cmd_opcode, 6'h11);
        check("R2 open drain", cmd_open_drain, 1);
        check("R2 rsp type", cmd_rsp_type, 2'd1);
        check("R2 busy wait", cmd_busy_wait, 1);
        check("R2 class", cmd_class, 2'd3);
        check("R2 read dir", cmd_read, 1);
        check("R3 arg", cmd_arg, 32'h1234_5678);
        rd(6'h0C, v); check("R2 readback", v, 32'h0000_B951);
        tick();
        check("R3 go one cycle", cmd_go, 0);
        rd(6'h2C, v); check("R4 busy bit", v, 32'h4);

        // R4 write while busy is ignored
        wr(6'h0C, 32'h0000_0005);
        check("R4 no go", cmd_go, 0);
        rd(6'h0C, v); check("R4 word kept", v, 32'h0000_B951);

        // R10 short response with end of command
        @(negedge clk);
        eng_rsp = {32'h3333_3333, 32'h2222_2222, 32'h1111_1111, 32'hCAFE_F00D};
        eng_rsp_valid = 1'b1; eng_cmd_done = 1'b1;
        @(negedge clk);
        eng_rsp_valid = 1'b0; eng_cmd_done = 1'b0;
        rd(6'h14, v); check("R10 short w0", v, 32'hCAFE_F00D);
        rd(6'h18, v); check("R10 short w1", v, 0);
        rd(6'h20, v); check("R10 short w3", v, 0);
        rd(6'h00, v); check("R5 end of cmd", v, 32'h1);
        rd(6'h2C, v); check("R4 busy cleared", v, 0);
        check("R8 irq on", irq, 1);
        wr(6'h00, 32'h1);
        rd(6'h00, v); check("R7 cleared", v, 0);
        check("R8 irq off", irq, 0);

        // R10 long response
        wr(6'h0C, 32'h0000_0202);
        check("R3 go long", cmd_go, 1);
        @(negedge clk);
        eng_rsp_valid = 1'b1; eng_cmd_done = 1'b1;
        @(negedge clk);
        eng_rsp_valid = 1'b0; eng_cmd_done = 1'b0;
        rd(6'h14, v); check("R10 long w0", v, 32'hCAFE_F00D);
        rd(6'h18, v); check("R10 long w1", v, 32'h1111_1111);
        rd(6'h1C, v); check("R10 long w2", v, 32'h2222_2222);
        rd(6'h20, v); check("R10 long w3", v, 32'h3333_3333);
        wr(6'h00, 32'hF);

        // R6 timeout with end of command in the same cycle
        wr(6'h0C, 32'h0000_0003);
        @(negedge clk);
        eng_timeout = 1'b1; eng_cmd_done = 1'b1;
        @(negedge clk);
        eng_timeout = 1'b0; eng_cmd_done = 1'b0;
        rd(6'h00, v); check("R6 timeout only", v, 32'h8);
        rd(6'h2C, v); check("R4 busy after timeout", v, 0);
        wr(6'h00, 32'h8);

        // R7 set wins over simultaneous clear
        @(negedge clk);
        bus_addr = 6'h00; bus_wdata = 32'h2; bus_wr = 1'b1;
        eng_data_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; eng_data_done = 1'b0;
        rd(6'h00, v); check("R7 set wins", v, 32'h2);

        // R8 masking leaves status alone
        wr(6'h04, 32'h0);
        check("R8 masked irq", irq, 0);
        rd(6'h00, v); check("R8 status kept", v, 32'h2);
        wr(6'h04, 32'h4);
        check("R8 other bit enabled", irq, 0);
        wr(6'h04, 32'h2);
        check("R8 matching bit enabled", irq, 1);

        // R9 card presence and write-protect changes
        @(negedge clk);
        card_present = 1'b1;
        @(negedge clk);
        rd(6'h00, v); check("R9 change event", v, 32'h6);
        rd(6'h2C, v); check("R9 present bit", v, 32'h1);
        wr(6'h00, 32'h4);
        rd(6'h00, v); check("R7 partial clear", v, 32'h2);
        tick(); tick();
        rd(6'h00, v); check("R9 no retrigger", v, 32'h2);
        @(negedge clk);
        card_ro = 1'b1;
        @(negedge clk);
        rd(6'h00, v); check("R9 ro event", v, 32'h6);
        rd(6'h2C, v); check("R9 ro bit", v, 32'h3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule